// File: doc/BRIEF.md
# Gigabit Ethernet Receive Elastic Buffer

This block is a dual-clock elastic buffer for a Gigabit Ethernet receive path. It sits between word alignment and 8B/10B decoding. Aligned 10-bit code groups enter in the recovered-clock domain and leave in the local reference-clock domain. The two clocks run at the same nominal rate: 125 MHz at 1.25 Gbps, or 312.5 MHz at 3.125 Gbps. The far-end transmitter and the local reference may each be off by up to ±100 ppm, so the offset between them can reach 200 ppm. The buffer absorbs that offset by removing or adding idle ordered sets inside inter-packet gaps.

Only the two-symbol idle set made of a comma K28.5 followed by D16.2 is ever used for compensation. A pair is removed on the write side when the write-side fill estimate is high. A pair is added on the read side when the read-side fill estimate is low, by emitting the pair that was just read a second time. Compensation is enabled by a link-synchronized input and is off until that input is high. While it is off, code groups pass through unchanged. The read side starts draining once the buffer reaches the midpoint of its two watermarks. After that it reads one code group on every read clock.

Top module: `rmf_top`

## Requirements
- R1: While reset is asserted, and after it is released until the buffer primes, `rd_valid`, `ins_pulse`, `del_pulse`, `ovf_flag` and `unf_flag` are all 0.
- R2: While `sync_ok` is 0, the sequence of valid code groups on `rd_data` equals the sequence written, with nothing dropped, added or reordered, and neither `ins_pulse` nor `del_pulse` fires.
- R3: Code groups are matched in both running-disparity forms: K28.5 = 10'b0011111010 or 10'b1100000101, D16.2 = 10'b1001000101 or 10'b0110110101. Only a K28.5 immediately followed by a D16.2 is ever added or removed, always as a whole pair. Every other code group, including K28.5 followed by D5.6 (10'b1010010110), keeps its order.
- R4: With `sync_ok` high, when a D16.2 arrives right after a K28.5 and the write-side fill is at or above HIGH_MARK, both symbols are discarded. `del_pulse` is then high for exactly one write clock. Two pulses never fall on adjacent cycles.
- R5: With synchronization seen on the read side and the read-side fill at or below LOW_MARK, a K28.5/D16.2 pair that has just been output is emitted once more. `ins_pulse` is high for one read clock, in the same cycle as the D16.2 that precedes the repeat. It is never high on two adjacent cycles. This may repeat without limit.
- R6: When the write clock runs faster than the read clock and idle pairs occur regularly, deletions occur and `ovf_flag` stays 0.
- R7: When the read clock runs faster than the write clock and idle pairs occur regularly, insertions occur and `unf_flag` stays 0.
- R8: A write that finds the buffer full sets `ovf_flag`. A read attempt on an empty buffer after priming sets `unf_flag`. Both flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered (write) clock |
| rclk | input | 1 | Local reference (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Code group valid on `wr_data` (wclk) |
| wr_data | input | 10 | Aligned code group (wclk) |
| sync_ok | input | 1 | Link synchronized, enables compensation (wclk) |
| rd_data | output | 10 | Output code group (rclk) |
| rd_valid | output | 1 | `rd_data` holds a code group (rclk) |
| ins_pulse | output | 1 | One-cycle pulse per inserted pair (rclk) |
| del_pulse | output | 1 | One-cycle pulse per deleted pair (wclk) |
| ovf_flag | output | 1 | Sticky overflow (wclk) |
| unf_flag | output | 1 | Sticky underflow (rclk) |

## Verification
Each result has its own due time:
- `del_pulse` rises on the write edge that follows the edge sampling the D16.2 of the dropped pair.
- `ins_pulse` appears on the same read edge that puts that pair's D16.2 on `rd_data`, and the repeated K28.5 follows one edge later.
- Each sticky flag rises one edge after the access that caused it.

A written code group reaches the output only after the staging register, pointer synchronization and priming. Its exact arrival cycle depends on clock phase. The bench therefore compares streams by order, not by cycle: exact order while synchronization is off, and order with all idle pairs removed while it is on. Pulses and flags are sampled on the falling edge of their own domain's clock, and counts and flags are judged only after each phase has run for thousands of cycles.

// File: rtl/rmf_pkg.sv
`timescale 1ns/1ps
package rmf_pkg;
   localparam int CG_W = 10;
   typedef logic [CG_W-1:0] cg_t;

   localparam cg_t COMMA_NEG = 10'b0011111010;
   localparam cg_t COMMA_POS = 10'b1100000101;
   localparam cg_t IDL2_NEG  = 10'b1001000101;
   localparam cg_t IDL2_POS  = 10'b0110110101;

   typedef enum logic [1:0] {
      RS_PASS,
      RS_REP_K,
      RS_REP_D
   } rd_state_e;

   function automatic logic is_comma(cg_t c);
      return (c == COMMA_NEG) || (c == COMMA_POS);
   endfunction

   function automatic logic is_idl2(cg_t c);
      return (c == IDL2_NEG) || (c == IDL2_POS);
   endfunction
endpackage

// File: rtl/rmf_ptr_sync.sv
`timescale 1ns/1ps
module rmf_ptr_sync #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_i,
   output logic [PW-1:0] bin_o
);
   logic [PW-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= gray_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   always_comb begin
      bin_o[PW-1] = chain_q[STAGES-1][PW-1];
      for (int i = PW - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ chain_q[STAGES-1][i];
   end
endmodule

// File: rtl/rmf_wr_side.sv
`timescale 1ns/1ps
module rmf_wr_side import rmf_pkg::*; #(
   parameter int AW        = 4,
   parameter int HIGH_MARK = 12
) (
   input  logic        wclk,
   input  logic        rst_n,
   input  logic        wr_en_i,
   input  cg_t         wr_data_i,
   input  logic        sync_i,
   input  logic [AW:0] rptr_bin_i,
   output logic        mem_we_o,
   output logic [AW-1:0] mem_waddr_o,
   output cg_t         mem_wdata_o,
   output logic [AW:0] wptr_gray_o,
   output logic        del_o,
   output logic        ovf_o
);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] HI_V    = PW'(HIGH_MARK);
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

   logic [PW-1:0] wptr_q, wptr_nxt, fill;
   cg_t           stg_q;
   logic          stg_v_q, del_q, ovf_q, full;
   logic          drop_pair, push, do_wr;

   assign fill      = wptr_q - rptr_bin_i;
   assign full      = fill[AW];
   assign drop_pair = wr_en_i && stg_v_q && is_comma(stg_q) && is_idl2(wr_data_i)
                      && sync_i && (fill >= HI_V);
   assign push      = wr_en_i && stg_v_q && !drop_pair;
   assign do_wr     = push && !full;
   assign wptr_nxt  = wptr_q + PW'(do_wr);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q      <= '0;
         wptr_gray_o <= '0;
         stg_q       <= '0;
         stg_v_q     <= 1'b0;
         del_q       <= 1'b0;
         ovf_q       <= 1'b0;
      end else begin
         wptr_q      <= wptr_nxt;
         wptr_gray_o <= wptr_nxt ^ (wptr_nxt >> 1);
         del_q       <= drop_pair;
         if (push && full) ovf_q <= 1'b1;
         if (wr_en_i) begin
            if (drop_pair) begin
               stg_v_q <= 1'b0;
            end else begin
               stg_q   <= wr_data_i;
               stg_v_q <= 1'b1;
            end
         end
      end
   end

   assign mem_we_o    = do_wr;
   assign mem_waddr_o = wptr_q[AW-1:0];
   assign mem_wdata_o = stg_q;
   assign del_o       = del_q;
   assign ovf_o       = ovf_q;

   p_del_spaced_r4: assert property (@(posedge wclk) disable iff (!rst_n) del_q |=> !del_q);
   p_del_high_r4:   assert property (@(posedge wclk) disable iff (!rst_n) del_q |-> $past(fill >= HI_V));
   p_del_sync_r2:   assert property (@(posedge wclk) disable iff (!rst_n) del_q |-> $past(sync_i));
   p_ovf_sticky_r8: assert property (@(posedge wclk) disable iff (!rst_n) ovf_q |=> ovf_q);
   p_wfill_cap_r6:  assert property (@(posedge wclk) disable iff (!rst_n) fill <= DEPTH_V);
endmodule

// File: rtl/rmf_rd_side.sv
`timescale 1ns/1ps
module rmf_rd_side import rmf_pkg::*; #(
   parameter int AW         = 4,
   parameter int LOW_MARK   = 4,
   parameter int PRIME_MARK = 8
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          sync_i,
   input  logic [AW:0]   wptr_bin_i,
   input  cg_t           mem_rdata_i,
   output logic [AW-1:0] mem_raddr_o,
   output logic [AW:0]   rptr_gray_o,
   output cg_t           rd_data_o,
   output logic          rd_valid_o,
   output logic          ins_o,
   output logic          unf_o
);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] LO_V    = PW'(LOW_MARK);
   localparam logic [PW-1:0] PRIME_V = PW'(PRIME_MARK);
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

   rd_state_e     st_q, st_nxt;
   logic [PW-1:0] rptr_q, rptr_nxt, fill;
   logic          run_q, lastk_q, ins_q, unf_q, valid_q;
   cg_t           kw_q, dw_q, out_w, data_q;
   logic          empty, pop, out_v, low, rep_start;

   assign fill     = wptr_bin_i - rptr_q;
   assign empty    = (fill == '0);
   assign pop      = run_q && (st_q == RS_PASS) && !empty;
   assign low      = sync_i && (fill <= LO_V);
   assign rptr_nxt = rptr_q + PW'(pop);

   always_comb begin
      out_w     = mem_rdata_i;
      out_v     = pop;
      rep_start = 1'b0;
      st_nxt    = st_q;
      case (st_q)
         RS_PASS: begin
            rep_start = pop && lastk_q && is_idl2(mem_rdata_i) && low;
            st_nxt    = rep_start ? RS_REP_K : RS_PASS;
         end
         RS_REP_K: begin
            out_w  = kw_q;
            out_v  = 1'b1;
            st_nxt = RS_REP_D;
         end
         RS_REP_D: begin
            out_w     = dw_q;
            out_v     = 1'b1;
            rep_start = low;
            st_nxt    = low ? RS_REP_K : RS_PASS;
         end
         default: st_nxt = RS_PASS;
      endcase
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= RS_PASS;
         rptr_q      <= '0;
         rptr_gray_o <= '0;
         run_q       <= 1'b0;
         lastk_q     <= 1'b0;
         ins_q       <= 1'b0;
         unf_q       <= 1'b0;
         valid_q     <= 1'b0;
         kw_q        <= '0;
         dw_q        <= '0;
         data_q      <= '0;
      end else begin
         st_q        <= st_nxt;
         rptr_q      <= rptr_nxt;
         rptr_gray_o <= rptr_nxt ^ (rptr_nxt >> 1);
         if (fill >= PRIME_V) run_q <= 1'b1;
         valid_q     <= out_v;
         if (out_v) data_q <= out_w;
         lastk_q     <= out_v && is_comma(out_w);
         if (out_v && is_comma(out_w)) kw_q <= out_w;
         if (pop && is_idl2(mem_rdata_i)) dw_q <= mem_rdata_i;
         ins_q       <= rep_start;
         if (run_q && (st_q == RS_PASS) && empty) unf_q <= 1'b1;
      end
   end

   assign mem_raddr_o = rptr_q[AW-1:0];
   assign rd_data_o   = data_q;
   assign rd_valid_o  = valid_q;
   assign ins_o       = ins_q;
   assign unf_o       = unf_q;

   p_ins_spaced_r5: assert property (@(posedge rclk) disable iff (!rst_n) ins_q |=> !ins_q);
   p_ins_on_d_r5:   assert property (@(posedge rclk) disable iff (!rst_n) ins_q |-> valid_q && is_idl2(data_q));
   p_ins_then_k_r3: assert property (@(posedge rclk) disable iff (!rst_n) ins_q |=> valid_q && is_comma(data_q));
   p_ins_sync_r2:   assert property (@(posedge rclk) disable iff (!rst_n) ins_q |-> $past(sync_i));
   p_unf_sticky_r8: assert property (@(posedge rclk) disable iff (!rst_n) unf_q |=> unf_q);
   p_rfill_cap_r7:  assert property (@(posedge rclk) disable iff (!rst_n) fill <= DEPTH_V);
endmodule

// File: rtl/rmf_top.sv
`timescale 1ns/1ps
module rmf_top import rmf_pkg::*; #(
   parameter int DEPTH       = 16,
   parameter int HIGH_MARK   = 12,
   parameter int LOW_MARK    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       wclk,
   input  logic       rclk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [9:0] wr_data,
   input  logic       sync_ok,
   output logic [9:0] rd_data,
   output logic       rd_valid,
   output logic       ins_pulse,
   output logic       del_pulse,
   output logic       ovf_flag,
   output logic       unf_flag
);
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;
   localparam int PRIME = (HIGH_MARK + LOW_MARK) / 2;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("rmf_top: DEPTH must be a power of two");
      end
      if (DEPTH < 4) begin : g_bad_small
         $error("rmf_top: DEPTH must be at least 4");
      end
      if (!(LOW_MARK < HIGH_MARK && HIGH_MARK < DEPTH && LOW_MARK > 0)) begin : g_bad_marks
         $error("rmf_top: need 0 < LOW_MARK < HIGH_MARK < DEPTH");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rmf_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   cg_t           mem_q [DEPTH];
   logic          mem_we;
   logic [AW-1:0] mem_waddr, mem_raddr;
   cg_t           mem_wdata, mem_rdata;
   logic [PW-1:0] wptr_gray, rptr_gray, wptr_in_r, rptr_in_w;
   logic [0:0]    sync_r;

   always_ff @(posedge wclk) begin
      if (mem_we) mem_q[mem_waddr] <= mem_wdata;
   end
   assign mem_rdata = mem_q[mem_raddr];

   rmf_wr_side #(.AW(AW), .HIGH_MARK(HIGH_MARK)) u_wr (
      .wclk        (wclk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .sync_i      (sync_ok),
      .rptr_bin_i  (rptr_in_w),
      .mem_we_o    (mem_we),
      .mem_waddr_o (mem_waddr),
      .mem_wdata_o (mem_wdata),
      .wptr_gray_o (wptr_gray),
      .del_o       (del_pulse),
      .ovf_o       (ovf_flag)
   );

   rmf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .gray_i(rptr_gray), .bin_o(rptr_in_w)
   );

   rmf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .gray_i(wptr_gray), .bin_o(wptr_in_r)
   );

   rmf_ptr_sync #(.PW(1), .STAGES(SYNC_STAGES)) u_sync (
      .clk(rclk), .rst_n(rst_n), .gray_i(sync_ok), .bin_o(sync_r)
   );

   rmf_rd_side #(.AW(AW), .LOW_MARK(LOW_MARK), .PRIME_MARK(PRIME)) u_rd (
      .rclk        (rclk),
      .rst_n       (rst_n),
      .sync_i      (sync_r[0]),
      .wptr_bin_i  (wptr_in_r),
      .mem_rdata_i (mem_rdata),
      .mem_raddr_o (mem_raddr),
      .rptr_gray_o (rptr_gray),
      .rd_data_o   (rd_data),
      .rd_valid_o  (rd_valid),
      .ins_o       (ins_pulse),
      .unf_o       (unf_flag)
   );

   p_reset_quiet_r1: assert property (@(posedge rclk) disable iff (!rst_n)
                                      $rose(rst_n) |-> !rd_valid && !ins_pulse);
endmodule

// File: tb/tb_rmf_top.sv
`timescale 1ns/1ps
module tb_rmf_top;
   localparam real WCLK_PERIOD = 8.0;
   localparam logic [9:0] BK_N   = 10'b0011111010;
   localparam logic [9:0] BK_P   = 10'b1100000101;
   localparam logic [9:0] BD16_N = 10'b1001000101;
   localparam logic [9:0] BD16_P = 10'b0110110101;
   localparam logic [9:0] BD56   = 10'b1010010110;

   logic wclk = 1'b0, rclk = 1'b0, rst_n;
   logic wr_en, sync_ok;
   logic [9:0] wr_data, rd_data;
   logic rd_valid, ins_pulse, del_pulse, ovf_flag, unf_flag;
   real  r_half;

   int total = 0, bad = 0;
   bit gen_on, raw_on, cmp_on, cnt_on;
   logic [9:0] pend[$], raw_q[$], cin_q[$];
   int raw_n = 0, raw_bad = 0, cmp_n = 0, cmp_bad = 0;
   int ins_cnt = 0, del_cnt = 0, ins_dbl = 0, del_dbl = 0;
   bit ins_prev = 0, del_prev = 0;
   bit ihold = 0, ohold = 0;
   logic [9:0] ikw, okw;

   rmf_top dut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sync_ok(sync_ok), .rd_data(rd_data), .rd_valid(rd_valid), .ins_pulse(ins_pulse),
      .del_pulse(del_pulse), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   always #(WCLK_PERIOD / 2.0) wclk = ~wclk;
   initial begin
      #1.3;
      forever #(r_half) rclk = ~rclk;
   end

   function automatic bit tb_k(logic [9:0] w);
      return (w == BK_N) || (w == BK_P);
   endfunction
   function automatic bit tb_d16(logic [9:0] w);
      return (w == BD16_N) || (w == BD16_P);
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic refill();
      int n;
      n = 4 + int'($urandom % 13);
      for (int i = 0; i < n; i++) begin
         logic [9:0] d;
         d = 10'($urandom);
         while (tb_k(d)) d = 10'($urandom);
         pend.push_back(d);
      end
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) begin
         pend.push_back(($urandom % 2) != 0 ? BK_P : BK_N);
         if (($urandom % 4) == 0) pend.push_back(BD56);
         else pend.push_back(($urandom % 2) != 0 ? BD16_P : BD16_N);
      end
   endtask

   // expected stream with every comma + D16.2 pair taken out
   task automatic in_feed(input logic [9:0] w);
      if (ihold) begin
         ihold = 0;
         if (!tb_d16(w)) begin
            cin_q.push_back(ikw);
            if (tb_k(w)) begin ihold = 1; ikw = w; end
            else cin_q.push_back(w);
         end
      end else if (tb_k(w)) begin
         ihold = 1; ikw = w;
      end else cin_q.push_back(w);
   endtask

   task automatic cmp_item(input logic [9:0] w);
      cmp_n++;
      if (cin_q.size() == 0) cmp_bad++;
      else if (cin_q.pop_front() != w) cmp_bad++;
   endtask

   task automatic out_feed(input logic [9:0] w);
      if (ohold) begin
         ohold = 0;
         if (!tb_d16(w)) begin
            cmp_item(okw);
            if (tb_k(w)) begin ohold = 1; okw = w; end
            else cmp_item(w);
         end
      end else if (tb_k(w)) begin
         ohold = 1; okw = w;
      end else cmp_item(w);
   endtask

   always @(negedge wclk) begin
      if (gen_on) begin
         logic [9:0] cur;
         if (pend.size() == 0) refill();
         cur = pend.pop_front();
         wr_en = 1'b1;
         wr_data = cur;
         if (raw_on) raw_q.push_back(cur);
         if (cmp_on) in_feed(cur);
      end else begin
         wr_en = 1'b0;
      end
   end

   always @(negedge wclk) begin
      if (rst_n && cnt_on && del_pulse) begin
         del_cnt++;
         if (del_prev) del_dbl++;
      end
      del_prev = del_pulse;
   end

   always @(negedge rclk) begin
      if (rst_n) begin
         if (cnt_on && ins_pulse) begin
            ins_cnt++;
            if (ins_prev) ins_dbl++;
         end
         if (rd_valid) begin
            if (raw_on) begin
               raw_n++;
               if (raw_q.size() == 0) raw_bad++;
               else if (raw_q.pop_front() != rd_data) raw_bad++;
            end
            if (cmp_on) out_feed(rd_data);
         end
      end
      ins_prev = ins_pulse;
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(WCLK_PERIOD * 150000.0);
      check(1'b0, "R1", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sync_ok = 1'b0;
      gen_on = 0; raw_on = 1; cmp_on = 1; cnt_on = 1;
      r_half = WCLK_PERIOD / 2.0;
      repeat (6) @(negedge wclk);
      // R1: reset state
      check(!rd_valid && !ins_pulse && !del_pulse, "R1", "valid/pulses in reset", int'({rd_valid, ins_pulse, del_pulse}), 0);
      check(!ovf_flag && !unf_flag, "R1", "flags in reset", int'({ovf_flag, unf_flag}), 0);
      rst_n = 1'b1;
      @(posedge wclk);
      gen_on = 1;
      @(negedge wclk);
      check(!rd_valid, "R1", "valid before priming", int'(rd_valid), 0);

      // R2: pass-through, no compensation before sync
      repeat (600) @(negedge wclk);
      check(raw_bad == 0, "R2", "raw stream mismatches", raw_bad, 0);
      check(raw_n >= 400, "R2", "raw words compared", raw_n, 400);
      check(ins_cnt + del_cnt == 0, "R2", "pulses without sync", ins_cnt + del_cnt, 0);

      // R4 / R6: writer faster
      sync_ok = 1'b1; raw_on = 0;
      ins_cnt = 0; del_cnt = 0; ins_dbl = 0; del_dbl = 0;
      r_half = 4.2;
      repeat (3000) @(negedge wclk);
      check(cmp_bad == 0, "R3", "idle-stripped mismatches (writer fast)", cmp_bad, 0);
      check(cmp_n > 1000, "R3", "stripped words compared", cmp_n, 1000);
      check(del_cnt > 0, "R4", "deletions seen", del_cnt, 1);
      check(del_dbl == 0, "R4", "adjacent deletion pulses", del_dbl, 0);
      check(!ovf_flag, "R6", "overflow with writer fast", int'(ovf_flag), 0);

      // R5 / R7: reader faster
      ins_cnt = 0; del_cnt = 0; ins_dbl = 0; del_dbl = 0;
      r_half = 3.8;
      repeat (3000) @(negedge wclk);
      check(cmp_bad == 0, "R3", "idle-stripped mismatches (reader fast)", cmp_bad, 0);
      check(ins_cnt > 0, "R5", "insertions seen", ins_cnt, 1);
      check(ins_dbl == 0, "R5", "adjacent insertion pulses", ins_dbl, 0);
      check(!unf_flag, "R7", "underflow with reader fast", int'(unf_flag), 0);

      // R8: real underflow then overflow, compensation off
      cmp_on = 0; cnt_on = 0; sync_ok = 1'b0;
      r_half = 3.5;
      repeat (500) @(negedge wclk);
      check(unf_flag, "R8", "underflow flag set", int'(unf_flag), 1);
      r_half = 4.5;
      repeat (600) @(negedge wclk);
      check(ovf_flag, "R8", "overflow flag set", int'(ovf_flag), 1);
      check(unf_flag, "R8", "underflow flag sticky", int'(unf_flag), 1);

      // R1 / R8: reset clears the sticky flags
      rst_n = 1'b0;
      repeat (4) @(negedge wclk);
      check(!ovf_flag && !unf_flag, "R8", "flags after reset", int'({ovf_flag, unf_flag}), 0);
      check(!rd_valid && !ins_pulse && !del_pulse, "R1", "outputs after reset", int'({rd_valid, ins_pulse, del_pulse}), 0);
      finish_run();
   end
endmodule